// File: doc/BRIEF.md
# Rank-Aware Bank Candidate Selector

This block sits in front of a memory controller's burst scheduler and narrows the set of queued requests to the banks worth considering for the next burst. Each cycle it looks at which banks of every rank hold a waiting request, the earliest cycle at which each of those banks could be activated, the rank that carried the previous burst, whether the next burst reverses the read/write direction, and the cycle at which the data bus becomes free. It returns a bank mask, registered once, that a downstream oldest-first picker uses to make the final choice.

The selector works out a reference cycle by taking the CAS latency and the activate-to-CAS delay off the bus-free time, so that it can be compared directly with activate times. It keeps using the rank of the previous burst when a bank there can be prepared in time to follow on seamlessly and the direction is unchanged. Otherwise it chooses the banks in the other ranks that can be prepared earliest. If the other ranks have nothing eligible, it falls back to the previous rank, so the output is never empty while an eligible request waits. Ranks that the refresh logic marks as blocked are left out before any of this happens.

Top module: `rank_bank_selector`

## Requirements
- R1: While `rst_n` is low at a rising edge, `bank_mask` becomes all zeros.
- R2: `bank_mask` is registered. The mask present after rising edge k is computed from the inputs sampled at edge k. Bit index r*BANKS_PER_RANK+b stands for bank b of rank r, and the same index selects the bit of `req_pending` and the TIME_W-wide slice of `act_ready_at` at bit offset index*TIME_W.
- R3: A bank is eligible only if its `req_pending` bit is set and its rank's `rank_blocked` bit is clear. `bank_mask` never has a bit set for a bank that is not eligible. With no eligible bank, `bank_mask` is zero.
- R4: Whenever at least one bank is eligible, `bank_mask` is not zero.
- R5: The reference cycle is `bus_free_at` minus (T_CL+T_RCD). It saturates at 0 when `bus_free_at` is smaller than that sum.
- R6: The previous rank is the one named by `prev_rank`. If `dir_switch` is low and that rank's earliest eligible activate time is at or before the reference cycle, the mask holds exactly the eligible banks of that rank whose activate time equals that earliest time. The equality case counts as in time.
- R7: When `dir_switch` is high and some other rank has an eligible bank, the previous rank is not preferred, however early its banks are.
- R8: If the previous rank's earliest eligible time is later than the reference cycle, and another rank has an eligible bank, the mask holds the eligible banks of the other ranks whose activate time equals the smallest such time across those ranks.
- R9: When every eligible bank lies in the previous rank, the mask holds that rank's earliest banks, whatever `dir_switch` is and whatever the reference cycle is.
- R10: All banks that tie on the winning earliest time are set together, both within a rank and across ranks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_pending | input | NUM_RANKS*BANKS_PER_RANK | A request waits for this bank |
| act_ready_at | input | NUM_RANKS*BANKS_PER_RANK*TIME_W | Earliest activate cycle per bank |
| rank_blocked | input | NUM_RANKS | Rank is unavailable (refresh) |
| prev_rank | input | RANK_W | Rank of the previous burst |
| dir_switch | input | 1 | Next burst changes read/write direction |
| bus_free_at | input | TIME_W | Cycle at which the data bus is free |
| bank_mask | output | NUM_RANKS*BANKS_PER_RANK | Candidate banks for the next burst |

## Verification
The bench aims at the reference boundary: a previous-rank bank exactly at the reference cycle must win, one cycle later must lose, and a bus-free time below the latency sum must clamp to zero rather than wrap, which would make every bank look in time. A design without the fallback would return an empty mask when all traffic sits in the previous rank. A design that ignores the direction flag would keep a stale rank across a turnaround. Further cases cover blocked ranks that leak through, ties of which only one bank is reported, and `prev_rank` pointing at either rank. Random stimulus is then compared with a reference model.

// File: rtl/bsel_pkg.sv
// Package: shared decision type and the saturating reference-time helper
// for the rank-aware bank selector. Assumes unsigned cycle stamps.
package bsel_pkg;

    typedef enum logic {
        PICK_CROSS = 1'b0,
        PICK_SAME  = 1'b1
    } pick_e;

    // Subtract a latency from a cycle stamp, clamping at zero.
    function automatic logic [31:0] sat_sub32(input logic [31:0] a, input logic [31:0] b);
        return (a >= b) ? (a - b) : 32'd0;
    endfunction

endpackage

// File: rtl/bsel_rank_scan.sv
// Module: per-rank scan. Finds the smallest activate time among the eligible
// banks of one rank and marks every eligible bank that ties on it.
// Assumes: times packed bank-major, TIME_W bits each; the min output is
// all ones and the tie mask empty when no bank is eligible.
module bsel_rank_scan #(
    parameter int BANKS  = 8,
    parameter int TIME_W = 16
) (
    input  logic [BANKS-1:0]        elig,
    input  logic [BANKS*TIME_W-1:0] times,
    output logic                    has_any,
    output logic [TIME_W-1:0]       min_t,
    output logic [BANKS-1:0]        tie_mask
);

    // Linear minimum search over eligible banks.
    always_comb begin
        min_t   = '1;
        has_any = 1'b0;
        for (int b = 0; b < BANKS; b++) begin
            if (elig[b] && (!has_any || times[b*TIME_W +: TIME_W] < min_t)) begin
                min_t = times[b*TIME_W +: TIME_W];
            end
            if (elig[b]) has_any = 1'b1;
        end
    end

    // Mark all eligible banks that share the minimum.
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            tie_mask[b] = elig[b] && (times[b*TIME_W +: TIME_W] == min_t);
        end
    end

endmodule

// File: rtl/bsel_cross_merge.sv
// Module: merges per-rank scan results. Separates the previous rank from the
// others, and forms the earliest-tie mask across all other ranks.
// Assumes: prev_rank may exceed NUM_RANKS-1; then no rank counts as previous.
module bsel_cross_merge #(
    parameter int RANKS  = 2,
    parameter int BANKS  = 8,
    parameter int TIME_W = 16,
    localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int NB     = RANKS * BANKS
) (
    input  logic [RANKS-1:0]        rank_has,
    input  logic [RANKS*TIME_W-1:0] rank_min,
    input  logic [NB-1:0]           rank_tie,
    input  logic [RANK_W-1:0]       prev_rank,
    output logic                    same_has,
    output logic [TIME_W-1:0]       same_min,
    output logic [NB-1:0]           same_mask,
    output logic                    cross_has,
    output logic [NB-1:0]           cross_mask
);

    logic [TIME_W-1:0] cross_min;

    // Pull out the previous rank's summary and place its tie mask.
    always_comb begin
        same_has  = 1'b0;
        same_min  = '1;
        same_mask = '0;
        for (int r = 0; r < RANKS; r++) begin
            if (RANK_W'(r) == prev_rank) begin
                same_has                   = rank_has[r];
                same_min                   = rank_min[r*TIME_W +: TIME_W];
                same_mask[r*BANKS +: BANKS] = rank_tie[r*BANKS +: BANKS];
            end
        end
    end

    // Earliest time among the other ranks that have candidates.
    always_comb begin
        cross_has = 1'b0;
        cross_min = '1;
        for (int r = 0; r < RANKS; r++) begin
            if (RANK_W'(r) != prev_rank && rank_has[r]) begin
                if (!cross_has || rank_min[r*TIME_W +: TIME_W] < cross_min) begin
                    cross_min = rank_min[r*TIME_W +: TIME_W];
                end
                cross_has = 1'b1;
            end
        end
    end

    // Collect tie masks of every other rank that reaches that time.
    always_comb begin
        cross_mask = '0;
        for (int r = 0; r < RANKS; r++) begin
            if (RANK_W'(r) != prev_rank && rank_has[r] &&
                rank_min[r*TIME_W +: TIME_W] == cross_min) begin
                cross_mask[r*BANKS +: BANKS] = rank_tie[r*BANKS +: BANKS];
            end
        end
    end

endmodule

// File: rtl/rank_bank_selector.sv
// Module: top of the rank-aware bank selector. Masks blocked ranks, scans
// each rank, derives the reference cycle, decides between previous-rank and
// cross-rank candidates and registers the mask.
// Assumes: bank index r*BANKS_PER_RANK+b; stamps are unsigned cycle counts.
module rank_bank_selector
    import bsel_pkg::*;
#(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 8,
    parameter int TIME_W         = 16,
    parameter int T_CL           = 12,
    parameter int T_RCD          = 12,
    localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int NB     = NUM_RANKS * BANKS_PER_RANK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NB-1:0]        req_pending,
    input  logic [NB*TIME_W-1:0] act_ready_at,
    input  logic [NUM_RANKS-1:0] rank_blocked,
    input  logic [RANK_W-1:0]    prev_rank,
    input  logic                 dir_switch,
    input  logic [TIME_W-1:0]    bus_free_at,
    output logic [NB-1:0]        bank_mask
);

    localparam int PREP_OFFSET = T_CL + T_RCD;

    logic [NB-1:0]               elig;
    logic [NUM_RANKS-1:0]        rank_has;
    logic [NUM_RANKS*TIME_W-1:0] rank_min;
    logic [NB-1:0]               rank_tie;
    logic                        same_has;
    logic [TIME_W-1:0]           same_min;
    logic [NB-1:0]               same_mask;
    logic                        cross_has;
    logic [NB-1:0]               cross_mask;
    logic [TIME_W-1:0]           ref_cycle;
    pick_e                       pick;
    logic [NB-1:0]               mask_next;
    logic                        primed;

    // Per rank: drop blocked ranks, then scan for the earliest banks.
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        assign elig[r*BANKS_PER_RANK +: BANKS_PER_RANK] =
            req_pending[r*BANKS_PER_RANK +: BANKS_PER_RANK] &
            {BANKS_PER_RANK{~rank_blocked[r]}};

        bsel_rank_scan #(
            .BANKS  (BANKS_PER_RANK),
            .TIME_W (TIME_W)
        ) u_scan (
            .elig     (elig[r*BANKS_PER_RANK +: BANKS_PER_RANK]),
            .times    (act_ready_at[r*BANKS_PER_RANK*TIME_W +: BANKS_PER_RANK*TIME_W]),
            .has_any  (rank_has[r]),
            .min_t    (rank_min[r*TIME_W +: TIME_W]),
            .tie_mask (rank_tie[r*BANKS_PER_RANK +: BANKS_PER_RANK])
        );
    end

    bsel_cross_merge #(
        .RANKS  (NUM_RANKS),
        .BANKS  (BANKS_PER_RANK),
        .TIME_W (TIME_W)
    ) u_merge (
        .rank_has   (rank_has),
        .rank_min   (rank_min),
        .rank_tie   (rank_tie),
        .prev_rank  (prev_rank),
        .same_has   (same_has),
        .same_min   (same_min),
        .same_mask  (same_mask),
        .cross_has  (cross_has),
        .cross_mask (cross_mask)
    );

    // Reference cycle aligned with activate timing, clamped at zero.
    always_comb begin
        ref_cycle = TIME_W'(sat_sub32(32'(bus_free_at), 32'(PREP_OFFSET)));
    end

    // Choose previous rank on seamless follow-on or when it is the only option.
    always_comb begin
        if (!cross_has) begin
            pick = PICK_SAME;
        end else if (!dir_switch && same_has && same_min <= ref_cycle) begin
            pick = PICK_SAME;
        end else begin
            pick = PICK_CROSS;
        end
        mask_next = (pick == PICK_SAME) ? same_mask : cross_mask;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) bank_mask <= '0;
        else        bank_mask <= mask_next;
    end

    // Marks that the output register has been loaded once since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // ---- assertions (port-level views for the checks) ----
    logic [NB-1:0] blocked_bits;
    logic [NB-1:0] prev_bits;
    logic          elig_any;
    logic          elig_other;

    // Port-derived views used only by the checks below.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            blocked_bits[i] = rank_blocked[i / BANKS_PER_RANK];
            prev_bits[i]    = (RANK_W'(i / BANKS_PER_RANK) == prev_rank);
        end
        elig_any   = |(req_pending & ~blocked_bits);
        elig_other = |(req_pending & ~blocked_bits & ~prev_bits);
    end

    assert_blocked_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> ((bank_mask & $past(blocked_bits)) == '0));

    assert_only_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> ((bank_mask & ~$past(req_pending)) == '0));

    assert_never_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(elig_any)) |-> (bank_mask != '0));

    assert_fallback_prev_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(elig_any) && !$past(elig_other)) |->
        ((bank_mask != '0) && ((bank_mask & ~$past(prev_bits)) == '0)));

    assert_switch_leaves_prev_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(dir_switch) && $past(elig_other)) |->
        ((bank_mask & $past(prev_bits)) == '0));

endmodule

// File: tb/tb_rank_bank_selector.sv
`timescale 1ns/100ps
module tb_rank_bank_selector;

    localparam int R  = 2;
    localparam int B  = 8;
    localparam int TW = 16;
    localparam int CL = 12;
    localparam int RCD = 12;
    localparam int NB = R * B;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB-1:0]     req_pending = '0;
    logic [NB*TW-1:0]  act_ready_at = '0;
    logic [R-1:0]      rank_blocked = '0;
    logic [0:0]        prev_rank = '0;
    logic              dir_switch = 1'b0;
    logic [TW-1:0]     bus_free_at = '0;
    logic [NB-1:0]     bank_mask;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic done = 1'b0;

    logic [TW-1:0] tm [NB];

    logic [NB-1:0] exp_q [$];
    int            due_q [$];
    string         tag_q [$];

    rank_bank_selector #(
        .NUM_RANKS(R), .BANKS_PER_RANK(B), .TIME_W(TW), .T_CL(CL), .T_RCD(RCD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_pending(req_pending),
        .act_ready_at(act_ready_at), .rank_blocked(rank_blocked),
        .prev_rank(prev_rank), .dir_switch(dir_switch),
        .bus_free_at(bus_free_at), .bank_mask(bank_mask)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model written from the requirements.
    function automatic logic [NB-1:0] model(input logic [NB-1:0] pend, input logic [R-1:0] blk,
                                            input int prev, input logic dsw, input int busy);
        logic [NB-1:0] el;
        logic [NB-1:0] smask;
        logic [NB-1:0] cmask;
        int refc, smin, cmin;
        bit shas, chas;
        el = '0; smask = '0; cmask = '0;
        shas = 0; chas = 0; smin = 0; cmin = 0;
        refc = (busy >= CL + RCD) ? busy - CL - RCD : 0;
        for (int i = 0; i < NB; i++) el[i] = pend[i] && !blk[i / B];
        for (int i = 0; i < NB; i++) begin
            if (!el[i]) continue;
            if (i / B == prev) begin
                if (!shas || int'(tm[i]) < smin) smin = int'(tm[i]);
                shas = 1;
            end else begin
                if (!chas || int'(tm[i]) < cmin) cmin = int'(tm[i]);
                chas = 1;
            end
        end
        for (int i = 0; i < NB; i++) begin
            if (el[i] && i / B == prev && int'(tm[i]) == smin) smask[i] = 1'b1;
            if (el[i] && i / B != prev && int'(tm[i]) == cmin) cmask[i] = 1'b1;
        end
        if (!chas) return smask;
        if (!dsw && shas && smin <= refc) return smask;
        return cmask;
    endfunction

    // Driver: apply one input set and queue its expected mask.
    task automatic apply(input logic [NB-1:0] pend, input logic [R-1:0] blk, input int prev,
                         input logic dsw, input int busy, input string tag);
        @(negedge clk);
        req_pending  = pend;
        rank_blocked = blk;
        prev_rank    = prev[0:0];
        dir_switch   = dsw;
        bus_free_at  = TW'(busy);
        for (int i = 0; i < NB; i++) act_ready_at[i*TW +: TW] = tm[i];
        exp_q.push_back(model(pend, blk, prev, dsw, busy));
        due_q.push_back(cyc + 1);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare results one edge after they were applied.
    always @(negedge clk) begin
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            checks++;
            if (bank_mask !== exp_q[0]) begin
                fails++;
                $display("FAIL %s: bank_mask=%h expected=%h", tag_q[0], bank_mask, exp_q[0]);
            end
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic clear_times(input int v);
        for (int i = 0; i < NB; i++) tm[i] = TW'(v);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        clear_times(0);
        req_pending = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (bank_mask !== '0) begin
            fails++;
            $display("FAIL R1: bank_mask=%h expected=0", bank_mask);
        end
        req_pending = '0;
        rst_n = 1'b1;

        // R6: previous rank in time, no direction change -> rank 0 ties 2 and 5
        clear_times(100);
        tm[2] = 10; tm[5] = 10; tm[B+1] = 3;
        apply(16'h0224, 2'b00, 0, 1'b0, 40, "R6 same-rank follow-on");
        // R7: direction change -> other rank
        apply(16'h0224, 2'b00, 0, 1'b1, 40, "R7 direction switch");
        // R8: previous rank late (ref=6) -> other rank
        apply(16'h0224, 2'b00, 0, 1'b0, 30, "R8 previous rank late");
        // R5/R6 equality: ref=10, same min 10 -> same
        apply(16'h0224, 2'b00, 0, 1'b0, 34, "R5 boundary equal");
        apply(16'h0224, 2'b00, 0, 1'b0, 33, "R5 boundary one late");
        // R5 saturation: bus 10 < 24 -> ref 0
        tm[2] = 0; tm[5] = 7;
        apply(16'h0224, 2'b00, 0, 1'b0, 10, "R5 clamp at zero wins");
        tm[2] = 1;
        apply(16'h0224, 2'b00, 0, 1'b0, 10, "R5 clamp at zero loses");
        // R9: all traffic in previous rank, even with switch and late
        clear_times(500);
        tm[3] = 200; tm[6] = 200; tm[7] = 300;
        apply(16'h00C8, 2'b00, 0, 1'b1, 0, "R9 only previous rank");
        apply(16'h00C8, 2'b00, 0, 1'b0, 0, "R9 only previous rank no switch");
        // R10: ties inside other rank
        clear_times(50);
        tm[B+0] = 5; tm[B+3] = 5; tm[B+7] = 5; tm[0] = 40;
        apply(16'h89FF, 2'b00, 0, 1'b1, 100, "R10 ties in other rank");
        // prev_rank=1 mirror, ties within previous rank
        apply(16'h89FF, 2'b00, 1, 1'b0, 100, "R10 ties in previous rank 1");
        apply(16'h89FF, 2'b00, 1, 1'b1, 100, "R7 switch with prev rank 1");
        // R3: blocked ranks
        apply(16'h89FF, 2'b10, 0, 1'b1, 100, "R3 other rank blocked");
        apply(16'h89FF, 2'b01, 0, 1'b0, 1000, "R3 previous rank blocked");
        apply(16'h89FF, 2'b11, 0, 1'b0, 100, "R3 all blocked");
        apply(16'h0000, 2'b00, 1, 1'b0, 100, "R3 nothing pending");
        // R2: back-to-back changing vectors
        apply(16'h0001, 2'b00, 1, 1'b0, 0, "R2 single bank rank 0");
        apply(16'h8000, 2'b00, 1, 1'b0, 0, "R2 single bank rank 1");

        // R4: random mix against the model
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < NB; i++) tm[i] = TW'($urandom_range(0, 40));
            apply(NB'($urandom), R'($urandom_range(0, 3) == 0 ? $urandom : 0),
                  int'($urandom_range(0, 1)), 1'($urandom), int'($urandom_range(0, 70)),
                  "R4 random");
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule